// File: doc/BRIEF.md
# Bit-Addressable Serial I/O Module

This block is a discrete I/O module with sixteen input pins and sixteen output pins. It sits on a processor I/O bus that moves one bit per access. The processor drives a 4-bit bit address, an active-low module select, an active-low serial write bit and an active-low store strobe. The module returns one active-low serial read bit.

On a read, the addressed input pin passes through a two-flop synchroniser, is selected by a multiplexer and comes back inverted: a low pin reads as logic 1. On a write, the addressed output flip-flop captures the inverse of the serial write line on a clock edge where both select and strobe are low.

Each stored 1 enables a low drive on its pad, in the manner of an open-collector stage. A stored 0 leaves the pad floating. The pad model is a per-bit drive enable plus a data value that is always low.

Top module: `bitio_module`

## Requirements
- R1: Address value k (straight binary, 0 to 15) selects input pin k for reads and output flip-flop k for writes.
- R2: Each input pin passes through two synchroniser flops before the read multiplexer, and the read output is registered. A pin change is therefore visible on `rd_data_n` at the third rising edge after the change, and not before.
- R3: With `mod_sel_n` low, `rd_data_n` after a rising edge equals the synchronised level of the addressed pin. A low pin gives a low `rd_data_n` (logic 1); a high pin gives a high `rd_data_n` (logic 0).
- R4: With `mod_sel_n` high at a rising edge, `rd_data_n` is high after that edge, whatever the pins and address are.
- R5: Output flip-flops change only at a rising edge where `mod_sel_n` and `store_n` are both low. If either is high, all sixteen stored bits keep their values.
- R6: A write changes only the addressed flip-flop. It stores the inverse of `wr_data_n`, so a low write line stores logic 1.
- R7: For each bit, a stored 1 sets `pad_oe[k]` high and a stored 0 sets it low. `pad_val` is all zeros at all times, so an enabled pad is driven low.
- R8: A synchronous active-high reset clears all stored bits, so `pad_oe` is all zeros. It also forces `rd_data_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Asynchronous input pins |
| bit_addr | input | 4 | Bit address from the processor |
| mod_sel_n | input | 1 | Active-low module select |
| store_n | input | 1 | Active-low write strobe |
| wr_data_n | input | 1 | Active-low serial write data |
| rd_data_n | output | 1 | Active-low serial read data |
| pad_oe | output | 16 | Per-bit low-drive enable |
| pad_val | output | 16 | Pad data value, always low |

## Verification
On every cycle, the assertions check four rules: the idle read level when the module is deselected, that the output bank stays frozen without a full select-and-strobe, that any write alters at most one stored bit, and that reset clears the bank. Some things only the bench scenarios can show. These are the bit-for-bit mapping from address to pin in both directions, the inverted polarity of reads and writes, and the exact three-edge input latency. The bench shows them by sweeping every address under several pin and write patterns.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Classify the current bus cycle from the active-low controls
  function automatic acc_kind_e classify(input logic sel_n, input logic stb_n);
    if (sel_n)      return ACC_IDLE;
    else if (!stb_n) return ACC_WRITE;
    else            return ACC_READ;
  endfunction
endpackage

// File: rtl/bitio_sync.sv
module bitio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async[g]};
      end
      assign q_sync[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bitio_rd_mux.sv
module bitio_rd_mux #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  sync_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  output logic              rd_n
);
  logic picked;

  // Logic value is the inverse of the pin; active-low line restores pin level
  assign picked = sync_in[addr];

  always_ff @(posedge clk) begin
    if (rst)        rd_n <= 1'b1;
    else if (sel_n) rd_n <= 1'b1;
    else            rd_n <= picked;
  end

  // R4: a deselected cycle leaves the read line at its idle level
  p_rd_idle_r4: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> rd_n);
endmodule

// File: rtl/bitio_wr_bank.sv
module bitio_wr_bank #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bit_val,
  output logic [WIDTH-1:0]  store_q
);
  logic [WIDTH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_ff
      assign hit[g] = wr_en && (addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
        if (rst)         store_q[g] <= 1'b0;
        else if (hit[g]) store_q[g] <= bit_val;
      end
    end
  endgenerate

  // R5: no write enable, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(store_q));
  // R6: a write alters at most one stored bit
  p_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> $countones(store_q ^ $past(store_q)) <= 1);
  // R8: reset empties the bank
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> store_q == '0);
endmodule

// File: rtl/bitio_module.sv
module bitio_module
  import bitio_pkg::*;
#(
  parameter int NUM_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] pin_in,
  input  logic [ADDR_W-1:0]   bit_addr,
  input  logic                mod_sel_n,
  input  logic                store_n,
  input  logic                wr_data_n,
  output logic                rd_data_n,
  output logic [NUM_BITS-1:0] pad_oe,
  output logic [NUM_BITS-1:0] pad_val
);
  acc_kind_e        kind;
  logic [NUM_BITS-1:0] sync_pins;
  logic [NUM_BITS-1:0] stored;

  assign kind = classify(mod_sel_n, store_n);

  bitio_sync #(.WIDTH(NUM_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(sync_pins));

  bitio_rd_mux #(.WIDTH(NUM_BITS), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .sync_in(sync_pins), .addr(bit_addr),
    .sel_n(mod_sel_n), .rd_n(rd_data_n));

  bitio_wr_bank #(.WIDTH(NUM_BITS), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .wr_en(kind == ACC_WRITE), .addr(bit_addr),
    .bit_val(~wr_data_n), .store_q(stored));

  // Open-collector model: enable drives a constant low
  assign pad_oe  = stored;
  assign pad_val = '0;
endmodule

// File: tb/test_bitio_module.sv
module test_bitio_module;
  localparam int N = 16;
  logic clk = 0, rst = 1;
  logic [N-1:0] pin_in = '0;
  logic [3:0] bit_addr = '0;
  logic mod_sel_n = 1, store_n = 1, wr_data_n = 1;
  logic rd_data_n;
  logic [N-1:0] pad_oe, pad_val;
  int total = 0, bad = 0;
  logic [N-1:0] model;

  always #10 clk = ~clk;

  bitio_module i_bitio_module (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bit_addr(bit_addr),
    .mod_sel_n(mod_sel_n), .store_n(store_n), .wr_data_n(wr_data_n),
    .rd_data_n(rd_data_n), .pad_oe(pad_oe), .pad_val(pad_val));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic v);
    @(negedge clk);
    bit_addr = 4'(a); mod_sel_n = 0; store_n = 0; wr_data_n = ~v;
    @(negedge clk);
    mod_sel_n = 1; store_n = 1; wr_data_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset oe", pad_oe, '0);
    chk("R8 reset rd", {15'b0, rd_data_n}, 16'd1);
    chk("R7 pad_val", pad_val, '0);

    // R1 R6 R7: write each bit of two patterns
    model = '0;
    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? 16'hA5C3 : 16'h5A3C;
      for (int k = 0; k < N; k++) begin
        do_write(k, pat[k]);
        model[k] = pat[k];
        chk("R6 write bit", pad_oe, model);
      end
    end
    chk("R7 pad_val low", pad_val, '0);

    // R5: blocked writes
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      bit_addr = 4'(k); wr_data_n = model[k];
      mod_sel_n = 0; store_n = 1;
      @(negedge clk);
      chk("R5 strobe high", pad_oe, model);
      mod_sel_n = 1; store_n = 0;
      @(negedge clk);
      chk("R5 select high", pad_oe, model);
      store_n = 1; wr_data_n = 1;
    end

    // R1 R3 R4: read sweeps
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      pin_in = 16'((p * 16'h1357) ^ (16'hFFFF >> p));
      repeat (3) @(negedge clk);
      for (int a = 0; a < N; a++) begin
        bit_addr = 4'(a); mod_sel_n = 0;
        @(negedge clk);
        chk("R3 read", {15'b0, rd_data_n}, {15'b0, pin_in[a]});
        mod_sel_n = 1;
        @(negedge clk);
        chk("R4 idle", {15'b0, rd_data_n}, 16'd1);
      end
    end

    // R2: latency
    bit_addr = 4'd7; mod_sel_n = 0; pin_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 settled", {15'b0, rd_data_n}, 16'd1);
    pin_in[7] = 1'b0;
    @(negedge clk);
    chk("R2 edge1", {15'b0, rd_data_n}, 16'd1);
    @(negedge clk);
    chk("R2 edge2", {15'b0, rd_data_n}, 16'd1);
    @(negedge clk);
    chk("R2 edge3", {15'b0, rd_data_n}, 16'd0);
    mod_sel_n = 1;

    // R8: reset with outputs set
    do_write(3, 1'b1);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R8 reset clears", pad_oe, '0);
    chk("R8 reset rd", {15'b0, rd_data_n}, 16'd1);
    rst = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule